// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block holds a calendar date (a four-digit year, a month and a day) as packed BCD and moves it forward one step at a time. The day advances on an advance pulse. That pulse comes either from the carry of the time-of-day counter or from a manual day key. The last day of each month is chosen from the month number and from whether the current year is a leap year. When the day passes that last day it returns to 01 and carries into the month. The month carries into the year in the same way.

Two more key inputs step the month and the year directly, so the date can be set by hand. If such a step leaves the day beyond the length of the new month, the day is pulled back to that month's last day on the following cycle. All three fields change on the same clock edge when a carry ripples through them. The outputs are read directly by a display multiplexer, which is not part of this block.

Top module: `cal_date_counter`

## Requirements
- R1: Reset loads the date year 0x2000, month 0x01, day 0x01, as packed BCD with the most significant digit in the top nibble.
- R2: The day advance pulse is the OR of `day_tick_i` and `day_key_i`. Both high in one cycle give a single step. With neither high and the day within the month, the date holds.
- R3: The day counts in BCD. A units digit below 9 increments, and a units digit of 9 becomes 0 and increments the tens digit (for example 0x09 to 0x10).
- R4: The last day is 0x31 for months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12, and 0x30 for months 0x04, 0x06, 0x09 and 0x11. An advance on the last day sets the day to 0x01 and advances the month on the same edge.
- R5: February ends on 0x29 in a leap year and on 0x28 otherwise. A year is a leap year when divisible by 4, except that a year ending in 00 must be divisible by 400 (2000 and 2024 leap; 2025 and 2100 not).
- R6: The month counts 0x01 to 0x12. An advance at 0x12, from a day carry or from `month_key_i`, returns it to 0x01 and advances the year on the same edge. A month key does not change the day, except through R8.
- R7: The year counts as four BCD digits. `year_key_i` adds one (2099 to 2100), and 9999 wraps to 0000.
- R8: When a month or year step leaves the day greater than the new month's last day, the day becomes that last day one cycle later.
- R9: A day carry and a month key in the same cycle advance the month by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| day_tick_i | input | 1 | Day carry from the time-of-day counter, one cycle per day |
| day_key_i | input | 1 | Manual day step, one-cycle pulse |
| month_key_i | input | 1 | Manual month step, one-cycle pulse |
| year_key_i | input | 1 | Manual year step, one-cycle pulse |
| year_o | output | 16 | Year, four BCD digits |
| month_o | output | 8 | Month, two BCD digits |
| day_o | output | 8 | Day, two BCD digits |

## Verification
Several properties are checked on every cycle:
- The day and month stay within their legal BCD ranges.
- A month carry is followed by day 01.
- An out-of-range day is clamped one cycle later.
- The date holds while no pulse arrives.
- A month step at 12 returns the month to 01.
- Every year digit stays decimal.

Only the bench scenarios can show that the month-length table is correct, including the leap-year choice for 2000, 2024, 2025 and 2100. The same holds for the exact date reached after long runs of ticks and keys, the wrap from 9999, and the coincidence of a day carry with a month key.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int DIGIT_W     = 4;
    localparam int YEAR_DIGITS = 4;
    localparam int YEAR_W      = YEAR_DIGITS * DIGIT_W;
    localparam int FIELD_W     = 2 * DIGIT_W;

    typedef logic [FIELD_W-1:0] bcd2_t;
    typedef logic [YEAR_W-1:0]  bcd_year_t;

    typedef struct packed {
        bcd2_t day;
    } day_state_t;

    typedef struct packed {
        bcd2_t month;
    } month_state_t;

    typedef struct packed {
        bcd_year_t year;
    } year_state_t;

    // Two-digit BCD number divisible by four: an even tens digit needs units 0/4/8,
    // an odd tens digit needs units 2/6.
    function automatic logic bcd2_div4(input bcd2_t v);
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
        tens  = v[FIELD_W-1:DIGIT_W];
        units = v[DIGIT_W-1:0];
        if (tens[0] == 1'b0)
            return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
        else
            return (units == 4'd2) || (units == 4'd6);
    endfunction

    // Two-digit BCD increment without range check.
    function automatic bcd2_t bcd2_inc(input bcd2_t v);
        bcd2_t r;
        if (v[DIGIT_W-1:0] == 4'd9) begin
            r[DIGIT_W-1:0]       = '0;
            r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W] + 4'd1;
        end else begin
            r[DIGIT_W-1:0]       = v[DIGIT_W-1:0] + 4'd1;
            r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_leap_detect.sv
module cal_leap_detect
    import cal_pkg::*;
(
    input  bcd_year_t year_i,
    output logic      leap_o
);

    localparam int LOW_HI  = FIELD_W - 1;
    localparam int HIGH_LO = FIELD_W;

    bcd2_t low_pair;
    bcd2_t high_pair;
    logic  century;

    always_comb begin
        low_pair  = year_i[LOW_HI:0];
        high_pair = year_i[YEAR_W-1:HIGH_LO];
        century   = (low_pair == '0);
        // A century year is a leap year only when its first two digits are a multiple of 4.
        leap_o    = century ? bcd2_div4(high_pair) : bcd2_div4(low_pair);
    end

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  bcd2_t month_i,
    input  logic  leap_i,
    output bcd2_t last_day_o
);

    always_comb begin
        unique case (month_i)
            8'h02:                      last_day_o = leap_i ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/cal_day_ctr.sv
module cal_day_ctr
    import cal_pkg::*;
#(
    parameter bcd2_t RST_DAY = 8'h01
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  adv_i,
    input  bcd2_t last_day_i,
    output bcd2_t day_o,
    output logic  mon_carry_o
);

    localparam bcd2_t FIRST_DAY = 8'h01;

    day_state_t st_d, st_q;
    logic       carry_d;

    always_comb begin
        st_d    = st_q;
        carry_d = adv_i && (st_q.day >= last_day_i);
        if (carry_d)
            st_d.day = FIRST_DAY;
        else if (adv_i)
            st_d.day = bcd2_inc(st_q.day);
        else if (st_q.day > last_day_i)
            st_d.day = last_day_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q.day <= RST_DAY;
        else
            st_q <= st_d;
    end

    assign day_o       = st_q.day;
    assign mon_carry_o = carry_d;

    // R3
    day_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.day != '0) && (st_q.day[DIGIT_W-1:0] <= 4'd9) && (st_q.day <= 8'h31));

    // R4
    day_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mon_carry_o |=> (st_q.day == FIRST_DAY));

    // R8
    day_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && (st_q.day > last_day_i)) |=> (st_q.day == $past(last_day_i)));

    // R2
    day_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && (st_q.day <= last_day_i)) |=> $stable(st_q.day));

endmodule

// File: rtl/cal_month_ctr.sv
module cal_month_ctr
    import cal_pkg::*;
#(
    parameter bcd2_t RST_MONTH = 8'h01
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  adv_i,
    output bcd2_t month_o,
    output logic  year_carry_o
);

    localparam bcd2_t FIRST_MONTH = 8'h01;
    localparam bcd2_t LAST_MONTH  = 8'h12;

    month_state_t st_d, st_q;
    logic         carry_d;

    always_comb begin
        st_d    = st_q;
        carry_d = adv_i && (st_q.month == LAST_MONTH);
        if (carry_d)
            st_d.month = FIRST_MONTH;
        else if (adv_i)
            st_d.month = bcd2_inc(st_q.month);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q.month <= RST_MONTH;
        else
            st_q <= st_d;
    end

    assign month_o      = st_q.month;
    assign year_carry_o = carry_d;

    // R6
    month_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.month >= FIRST_MONTH) && (st_q.month <= LAST_MONTH)
        && (st_q.month[DIGIT_W-1:0] <= 4'd9));

    // R6
    month_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && (st_q.month == LAST_MONTH)) |=> (st_q.month == FIRST_MONTH));

    // R9
    month_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(st_q.month));

endmodule

// File: rtl/cal_year_ctr.sv
module cal_year_ctr
    import cal_pkg::*;
#(
    parameter bcd_year_t RST_YEAR = 16'h2000
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      adv_i,
    output bcd_year_t year_o
);

    year_state_t            st_d, st_q;
    bcd_year_t              inc_val;
    logic [YEAR_DIGITS:0]   ripple;
    logic [YEAR_DIGITS-1:0] at_nine;

    assign ripple[0] = 1'b1;

    for (genvar g = 0; g < YEAR_DIGITS; g++) begin : g_digit
        logic [DIGIT_W-1:0] dig;
        assign dig             = st_q.year[g*DIGIT_W +: DIGIT_W];
        assign at_nine[g]      = (dig == 4'd9);
        assign ripple[g+1]     = ripple[g] && at_nine[g];
        assign inc_val[g*DIGIT_W +: DIGIT_W] =
            !ripple[g] ? dig : (at_nine[g] ? 4'd0 : dig + 4'd1);

        // R7
        year_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_q.year[g*DIGIT_W +: DIGIT_W] <= 4'd9);
    end

    always_comb begin
        st_d = st_q;
        if (adv_i)
            st_d.year = inc_val;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q.year <= RST_YEAR;
        else
            st_q <= st_d;
    end

    assign year_o = st_q.year;

    // R7
    year_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(st_q.year));

endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
    import cal_pkg::*;
#(
    parameter logic [15:0] RST_YEAR  = 16'h2000,
    parameter logic [7:0]  RST_MONTH = 8'h01,
    parameter logic [7:0]  RST_DAY   = 8'h01
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        day_tick_i,
    input  logic        day_key_i,
    input  logic        month_key_i,
    input  logic        year_key_i,
    output logic [15:0] year_o,
    output logic [7:0]  month_o,
    output logic [7:0]  day_o
);

    logic      day_adv;
    logic      month_adv;
    logic      year_adv;
    logic      mon_carry;
    logic      year_carry;
    logic      leap;
    bcd2_t     last_day;
    bcd2_t     month_q;
    bcd2_t     day_q;
    bcd_year_t year_q;

    assign day_adv   = day_tick_i | day_key_i;
    assign month_adv = mon_carry | month_key_i;
    assign year_adv  = year_carry | year_key_i;

    cal_leap_detect u_leap (
        .year_i (year_q),
        .leap_o (leap)
    );

    cal_month_len u_len (
        .month_i    (month_q),
        .leap_i     (leap),
        .last_day_o (last_day)
    );

    cal_day_ctr #(.RST_DAY(RST_DAY)) u_day (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .adv_i       (day_adv),
        .last_day_i  (last_day),
        .day_o       (day_q),
        .mon_carry_o (mon_carry)
    );

    cal_month_ctr #(.RST_MONTH(RST_MONTH)) u_month (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .adv_i        (month_adv),
        .month_o      (month_q),
        .year_carry_o (year_carry)
    );

    cal_year_ctr #(.RST_YEAR(RST_YEAR)) u_year (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (year_adv),
        .year_o (year_q)
    );

    assign year_o  = year_q;
    assign month_o = month_q;
    assign day_o   = day_q;

    // R4
    carry_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_carry && !month_key_i && (month_q != 8'h12)) |=> $stable(year_q));

endmodule

// File: tb/cal_date_counter_tb_top.sv
`timescale 1ns/1ps
module cal_date_counter_tb_top;

    localparam realtime CLK_HALF = 2.0;
    localparam int      WATCHDOG_CYC = 200000;

    localparam logic [3:0] P_NONE = 4'b0000;
    localparam logic [3:0] P_TICK = 4'b1000;
    localparam logic [3:0] P_DKEY = 4'b0100;
    localparam logic [3:0] P_MKEY = 4'b0010;
    localparam logic [3:0] P_YKEY = 4'b0001;

    typedef struct packed {
        logic [23:0] tag;
        logic [3:0]  pulse;
        logic [15:0] count;
        logic [15:0] yr;
        logic [7:0]  mo;
        logic [7:0]  dy;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t VECS [NVEC] = '{
        '{"R3 ", P_TICK,          16'd30,   16'h2000, 8'h01, 8'h31},
        '{"R4 ", P_TICK,          16'd1,    16'h2000, 8'h02, 8'h01},
        '{"R5 ", P_DKEY,          16'd28,   16'h2000, 8'h02, 8'h29},
        '{"R2 ", P_TICK | P_DKEY, 16'd1,    16'h2000, 8'h03, 8'h01},
        '{"R4 ", P_TICK,          16'd30,   16'h2000, 8'h03, 8'h31},
        '{"R4 ", P_TICK,          16'd1,    16'h2000, 8'h04, 8'h01},
        '{"R3 ", P_TICK,          16'd29,   16'h2000, 8'h04, 8'h30},
        '{"R4 ", P_TICK,          16'd1,    16'h2000, 8'h05, 8'h01},
        '{"R6 ", P_MKEY,          16'd7,    16'h2000, 8'h12, 8'h01},
        '{"R4 ", P_TICK,          16'd30,   16'h2000, 8'h12, 8'h31},
        '{"R6 ", P_TICK,          16'd1,    16'h2001, 8'h01, 8'h01},
        '{"R7 ", P_YKEY,          16'd23,   16'h2024, 8'h01, 8'h01},
        '{"R6 ", P_MKEY,          16'd1,    16'h2024, 8'h02, 8'h01},
        '{"R5 ", P_TICK,          16'd28,   16'h2024, 8'h02, 8'h29},
        '{"R5 ", P_TICK,          16'd1,    16'h2024, 8'h03, 8'h01},
        '{"R6 ", P_MKEY,          16'd10,   16'h2025, 8'h01, 8'h01},
        '{"R6 ", P_MKEY,          16'd1,    16'h2025, 8'h02, 8'h01},
        '{"R5 ", P_TICK,          16'd27,   16'h2025, 8'h02, 8'h28},
        '{"R5 ", P_TICK,          16'd1,    16'h2025, 8'h03, 8'h01},
        '{"R7 ", P_YKEY,          16'd74,   16'h2099, 8'h03, 8'h01},
        '{"R6 ", P_MKEY,          16'd11,   16'h2100, 8'h02, 8'h01},
        '{"R5 ", P_TICK,          16'd27,   16'h2100, 8'h02, 8'h28},
        '{"R5 ", P_TICK,          16'd1,    16'h2100, 8'h03, 8'h01},
        '{"R7 ", P_YKEY,          16'd7899, 16'h9999, 8'h03, 8'h01},
        '{"R7 ", P_YKEY,          16'd1,    16'h0000, 8'h03, 8'h01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        day_tick = 1'b0;
    logic        day_key = 1'b0;
    logic        month_key = 1'b0;
    logic        year_key = 1'b0;
    logic [15:0] year;
    logic [7:0]  month;
    logic [7:0]  day;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    cal_date_counter dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .day_tick_i  (day_tick),
        .day_key_i   (day_key),
        .month_key_i (month_key),
        .year_key_i  (year_key),
        .year_o      (year),
        .month_o     (month),
        .day_o       (day)
    );

    task automatic drive(input logic [3:0] p);
        {day_tick, day_key, month_key, year_key} = p;
    endtask

    // n pulsed edges, then sample at the falling edge after the last one;
    // n = 0 lets exactly one idle edge pass before sampling.
    task automatic run(input logic [3:0] p, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive(p);
        end
        @(negedge clk);
        drive(P_NONE);
    endtask

    task automatic check(input string tag, input logic [15:0] ey,
                         input logic [7:0] em, input logic [7:0] ed);
        applied++;
        if ({year, month, day} !== {ey, em, ed}) begin
            bad++;
            $display("FAIL %s: got %h-%h-%h expected %h-%h-%h",
                     tag, year, month, day, ey, em, ed);
        end
    endtask

    initial begin
        drive(P_NONE);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", 16'h2000, 8'h01, 8'h01);

        for (int v = 0; v < NVEC; v++) begin
            run(VECS[v].pulse, int'(VECS[v].count));
            check(string'(VECS[v].tag), VECS[v].yr, VECS[v].mo, VECS[v].dy);
        end

        // R8 month key from day 31 into February of a leap year
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 16'h2000, 8'h01, 8'h01);
        run(P_TICK, 30);
        check("R3", 16'h2000, 8'h01, 8'h31);
        run(P_MKEY, 1);
        check("R8", 16'h2000, 8'h02, 8'h31);
        run(P_NONE, 0);
        check("R8", 16'h2000, 8'h02, 8'h29);

        // R8 year key into a common year
        run(P_YKEY, 1);
        check("R8", 16'h2001, 8'h02, 8'h29);
        run(P_NONE, 0);
        check("R8", 16'h2001, 8'h02, 8'h28);

        // R9 day carry together with month key
        run(P_TICK | P_MKEY, 1);
        check("R9", 16'h2001, 8'h03, 8'h01);

        // R2 no pulse: date holds
        for (int k = 0; k < 5; k++) begin
            run(P_NONE, 0);
            check("R2", 16'h2001, 8'h03, 8'h01);
        end

        // R1 reset in mid-run
        run(P_TICK, 12);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 16'h2000, 8'h01, 8'h01);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            applied++;
            bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

endmodule